// File: doc/BRIEF.md
# Tagged Set-Associative Indirect-Call Target Buffer

This block stores predicted destinations for indirect calls, keyed by a hash that the surrounding fetch logic forms by XOR-ing a global record of recent call targets with the address of the calling instruction. The low bits of that hash pick a set. The remaining high bits are kept in each entry as a tag. A prediction is offered only when a valid way of the chosen set holds a matching tag. Two different path patterns that land in one set therefore keep their own targets in separate ways. A single shared slot would make one pattern's target stand in for the other's.

The front end issues a lookup with a hash and receives a registered hit flag and target one cycle later. A hit flag of zero means no prediction. When a call resolves, the back end issues an update with the same hash and the actual destination. If the tag is already present, that way is rewritten in place. Otherwise a new way is allocated. Empty ways are used first. When the set is full, the way whose last update is oldest is replaced. Recency is driven by updates only. The number of sets and ways are parameters. The defaults give 256 sets of 8 ways, which is 2048 entries.

Top module: `tpb_tagged_target_buf`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid` and `rsp_hit` are 0. After reset every lookup misses until an update writes that hash.
- R2: The hash is split as set = `hash[IDX_W-1:0]` and tag = `hash[HASH_W-1:IDX_W]`. A lookup asserted in cycle N gives `rsp_valid`=1 in cycle N+1. In that cycle `rsp_hit`=1, and `rsp_target` equals the last target written for that exact hash, only if a valid way of that set holds that tag.
- R3: Up to WAYS hashes sharing one set but differing in tag are all held at once, and each returns its own target. At most one way of a set matches a given tag.
- R4: An update whose hash is already present rewrites that way's target in place, without taking a second way.
- R5: An update whose hash is absent fills the lowest-numbered invalid way of its set. If no way is invalid, it replaces the way whose most recent update is oldest.
- R6: An update that hits makes that way the most recently updated in its set.
- R7: A cycle without `lk_valid` produces `rsp_valid`=0 and `rsp_hit`=0 one cycle later.
- R8: When a lookup and an update fall in the same cycle, the lookup sees the contents from before that update. The update becomes visible to lookups from the next cycle.
- R9: Lookups do not change replacement order.
- R10: Updates to one set never evict or alter entries of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_hash | input | HASH_W | Hashed path history and call-site address for the lookup |
| upd_valid | input | 1 | Update request for a resolved call |
| upd_hash | input | HASH_W | Hash of the resolved call |
| upd_target | input | TGT_W | Actual destination of the resolved call |
| rsp_valid | output | 1 | Registered: a lookup was issued in the previous cycle |
| rsp_hit | output | 1 | Registered: that lookup found a matching tag |
| rsp_target | output | TGT_W | Registered predicted destination; zero on a miss |

## Verification
A lookup and an update can land in the same cycle, and the interesting case is when both carry the same hash. The bench provokes this twice on a fresh set. First it pairs the lookup with the update that allocates the hash, and expects a miss. Then it pairs the lookup with an update that rewrites the target, and expects the old target. In both cases a lookup one cycle later must show the new contents.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

    // Kind of write an update performs in the current cycle.
    typedef enum logic [1:0] {
        UPD_NONE    = 2'd0,
        UPD_REFRESH = 2'd1,
        UPD_ALLOC   = 2'd2
    } upd_kind_e;

    // Bits needed to number n items, never less than one.
    function automatic int num_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tpb_way_match.sv
module tpb_way_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 8,
    parameter int WAY_W = 3
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            query_tag,
    output logic [WAYS-1:0]             match_vec,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = way_valid[w] && (way_tag[w] == query_tag);
    end

    assign hit = |match_vec;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tpb_lru_bank.sv
module tpb_lru_bank #(
    parameter int SETS  = 256,
    parameter int WAYS  = 8,
    parameter int IDX_W = 8,
    parameter int WAY_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                touch_en,
    input  logic [IDX_W-1:0]    touch_set,
    input  logic [WAY_W-1:0]    touch_way,
    input  logic [WAYS-1:0]     set_valid,
    output logic [WAY_W-1:0]    victim_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    // Age 0 is the most recently updated way, WAYS-1 the oldest.
    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;
    logic             any_free;

    always_comb begin
        free_way = '0;
        old_way  = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
            if (age_q[touch_set][w] == OLDEST) old_way = WAY_W'(w);
        end
        victim_way = any_free ? free_way : old_way;
    end
endmodule

// File: rtl/tpb_tagged_target_buf.sv
module tpb_tagged_target_buf
    import tpb_pkg::*;
#(
    parameter int HASH_W = 16,
    parameter int SETS   = 256,
    parameter int WAYS   = 8,
    parameter int TGT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [HASH_W-1:0] lk_hash,
    input  logic              upd_valid,
    input  logic [HASH_W-1:0] upd_hash,
    input  logic [TGT_W-1:0]  upd_target,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [TGT_W-1:0]  rsp_target
);
    localparam int IDX_W = num_bits(SETS);
    localparam int TAG_W = HASH_W - IDX_W;
    localparam int WAY_W = num_bits(WAYS);

    logic [WAYS-1:0]             valid_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q    [SETS];
    logic [WAYS-1:0][TGT_W-1:0]  target_q [SETS];

    logic [IDX_W-1:0] lk_set, upd_set;
    logic [TAG_W-1:0] lk_tag, upd_tag;

    assign lk_set  = lk_hash[IDX_W-1:0];
    assign lk_tag  = lk_hash[HASH_W-1:IDX_W];
    assign upd_set = upd_hash[IDX_W-1:0];
    assign upd_tag = upd_hash[HASH_W-1:IDX_W];

    logic [WAYS-1:0]  lk_match, upd_match;
    logic             lk_hit, upd_hit;
    logic [WAY_W-1:0] lk_way, upd_way, victim_way;

    tpb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
        .way_valid (valid_q[lk_set]),
        .way_tag   (tag_q[lk_set]),
        .query_tag (lk_tag),
        .match_vec (lk_match),
        .hit       (lk_hit),
        .hit_way   (lk_way)
    );

    tpb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_upd_match (
        .way_valid (valid_q[upd_set]),
        .way_tag   (tag_q[upd_set]),
        .query_tag (upd_tag),
        .match_vec (upd_match),
        .hit       (upd_hit),
        .hit_way   (upd_way)
    );

    upd_kind_e        upd_kind;
    logic [WAY_W-1:0] wr_way;
    logic             wr_en;

    always_comb begin
        if (!upd_valid)   upd_kind = UPD_NONE;
        else if (upd_hit) upd_kind = UPD_REFRESH;
        else              upd_kind = UPD_ALLOC;
        wr_en  = (upd_kind != UPD_NONE);
        wr_way = (upd_kind == UPD_REFRESH) ? upd_way : victim_way;
    end

    tpb_lru_bank #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (wr_en),
        .touch_set  (upd_set),
        .touch_way  (wr_way),
        .set_valid  (valid_q[upd_set]),
        .victim_way (victim_way)
    );

    // Valid bits and the registered response are reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_target <= '0;
        end else begin
            if (wr_en) valid_q[upd_set][wr_way] <= 1'b1;
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && lk_hit;
            rsp_target <= (lk_valid && lk_hit) ? target_q[lk_set][lk_way] : '0;
        end
    end

    // Tag and target storage carries no reset; valid bits qualify it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[upd_set][wr_way]    <= upd_tag;
            target_q[upd_set][wr_way] <= upd_target;
        end
    end
endmodule

// File: rtl/tpb_checker.sv
module tpb_checker #(
    parameter int WAYS  = 8,
    parameter int WAY_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAYS-1:0]  lk_match,
    input logic [WAYS-1:0]  upd_match,
    input logic             upd_valid,
    input logic             upd_hit,
    input logic [WAYS-1:0]  upd_set_valid,
    input logic [WAY_W-1:0] victim_way
);
    // R1: no response flags right after a reset cycle
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_hit));

    // R7: a hit is only reported alongside a response
    a_r7_hit_needs_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R7: response strobe follows the request by one cycle
    a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R2: a request always produces a response
    a_r2_req_answered: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R3: at most one way of a set holds a given tag
    a_r3_single_match_lk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    a_r3_single_match_upd: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_match));

    // R5: an allocation into a set with room lands in an empty way
    a_r5_fill_empty_first: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_hit && !(&upd_set_valid)) |-> !upd_set_valid[victim_way]);
endmodule

bind tpb_tagged_target_buf tpb_checker #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .lk_match      (lk_match),
    .upd_match     (upd_match),
    .upd_valid     (upd_valid),
    .upd_hit       (upd_hit),
    .upd_set_valid (valid_q[upd_set]),
    .victim_way    (victim_way)
);

// File: tb/sim_tpb_tagged_target_buf.sv
module sim_tpb_tagged_target_buf;
    localparam int HASH_W = 16;
    localparam int TGT_W  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [HASH_W-1:0] lk_hash = '0;
    logic              upd_valid = 1'b0;
    logic [HASH_W-1:0] upd_hash = '0;
    logic [TGT_W-1:0]  upd_target = '0;
    logic              rsp_valid, rsp_hit;
    logic [TGT_W-1:0]  rsp_target;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tpb_tagged_target_buf u0 (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_hash(lk_hash),
        .upd_valid(upd_valid), .upd_hash(upd_hash), .upd_target(upd_target),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target)
    );

    // Scoreboard queues, one item per issued lookup.
    bit          exp_hit_q [$];
    logic [31:0] exp_tgt_q [$];
    string       exp_req_q [$];

    function automatic logic [15:0] hh(input int set, input int tag);
        return {8'(tag), 8'(set)};
    endfunction

    function automatic logic [31:0] tv(input int set, input int tag, input int gen);
        return {8'(8'hC0 ^ gen), 8'(set), 8'(tag), 8'h5A};
    endfunction

    task automatic step(input bit lk, input logic [15:0] lh,
                        input bit up, input logic [15:0] uh, input logic [31:0] ut,
                        input bit ehit, input logic [31:0] etgt, input string req);
        @(negedge clk);
        lk_valid   = lk;
        lk_hash    = lh;
        upd_valid  = up;
        upd_hash   = uh;
        upd_target = ut;
        if (lk) begin
            exp_hit_q.push_back(ehit);
            exp_tgt_q.push_back(etgt);
            exp_req_q.push_back(req);
        end
    endtask

    task automatic look(input int set, input int tag, input bit ehit,
                        input logic [31:0] etgt, input string req);
        step(1'b1, hh(set, tag), 1'b0, '0, '0, ehit, etgt, req);
    endtask

    task automatic write(input int set, input int tag, input logic [31:0] t);
        step(1'b0, '0, 1'b1, hh(set, tag), t, 1'b0, '0, "");
    endtask

    // Monitor: compare each response against the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && rsp_valid) begin
                total++;
                if (exp_hit_q.size() == 0) begin
                    bad++;
                    $display("FAIL R7: response with no request, actual valid=%0b expected valid=0", rsp_valid);
                end else begin
                    automatic bit          eh = exp_hit_q.pop_front();
                    automatic logic [31:0] et = exp_tgt_q.pop_front();
                    automatic string       er = exp_req_q.pop_front();
                    if (rsp_hit !== eh || (eh && rsp_target !== et)) begin
                        bad++;
                        $display("FAIL %s: actual hit=%0b target=%h expected hit=%0b target=%h",
                                 er, rsp_hit, rsp_target, eh, et);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: no response while in reset
        repeat (3) begin
            @(negedge clk);
            lk_valid = 1'b1;
            total++;
            if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
                bad++;
                $display("FAIL R1: actual valid=%0b hit=%0b expected 0 0", rsp_valid, rsp_hit);
            end
        end
        @(negedge clk);
        lk_valid = 1'b0;
        rst = 1'b0;

        // R1: everything misses after reset
        look(5, 1, 0, '0, "R1");
        look(0, 0, 0, '0, "R1");
        look(255, 255, 0, '0, "R1");

        // R10: entry in a neighbouring set
        write(6, 1, tv(6, 1, 0));

        // R3: fill all eight ways of set 5
        for (int t = 1; t <= 8; t++) write(5, t, tv(5, t, 0));
        for (int t = 1; t <= 8; t++) look(5, t, 1, tv(5, t, 0), "R3");

        // R2: wrong tag and wrong set both miss
        look(5, 20, 0, '0, "R2");
        look(4, 1, 0, '0, "R2");

        // R5: full set evicts the oldest update (tag 1)
        write(5, 9, tv(5, 9, 0));
        look(5, 1, 0, '0, "R5");
        look(5, 9, 1, tv(5, 9, 0), "R5");

        // R4 and R6: rewrite tag 2, then allocate; tag 3 is now the oldest
        write(5, 2, tv(5, 2, 1));
        write(5, 10, tv(5, 10, 0));
        look(5, 3, 0, '0, "R6");
        look(5, 2, 1, tv(5, 2, 1), "R4");
        look(5, 10, 1, tv(5, 10, 0), "R5");

        // R9: lookups of tag 4 do not protect it from eviction
        repeat (3) look(5, 4, 1, tv(5, 4, 0), "R9");
        write(5, 11, tv(5, 11, 0));
        look(5, 4, 0, '0, "R9");

        // R4: eight distinct residents remain, rewritten one not duplicated
        look(5, 2, 1, tv(5, 2, 1), "R4");
        for (int t = 5; t <= 11; t++) look(5, t, 1, tv(5, t, 0), "R4");

        // R10: other set untouched
        look(6, 1, 1, tv(6, 1, 0), "R10");

        // R8: same-cycle lookup and allocation of one hash
        step(1'b1, hh(7, 3), 1'b1, hh(7, 3), tv(7, 3, 0), 1'b0, '0, "R8");
        look(7, 3, 1, tv(7, 3, 0), "R8");
        // R8: same-cycle lookup and in-place rewrite
        step(1'b1, hh(7, 3), 1'b1, hh(7, 3), tv(7, 3, 2), 1'b1, tv(7, 3, 0), "R8");
        look(7, 3, 1, tv(7, 3, 2), "R8");

        // R7: idle cycle gives no response
        step(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, "");
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        total++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            bad++;
            $display("FAIL R7: actual valid=%0b hit=%0b expected 0 0", rsp_valid, rsp_hit);
        end

        repeat (4) @(posedge clk);
        total++;
        if (exp_hit_q.size() != 0) begin
            bad++;
            $display("FAIL R2: actual pending=%0d expected pending=0", exp_hit_q.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule